// File: doc/BRIEF.md
# Serial Programming Port Byte Reader

This block is the host side of a two-wire serial programming link: one clock line that the host always drives, and one data line that both ends share. A single start pulse together with a 22-bit target address makes the host fetch one byte of the target's memory. The host serialises six core-instruction frames that load the three bytes of the target's table pointer. It then serialises a table-read frame, turns the data line round while the clock is held low, clocks the byte back in and reports it with a one-cycle done strobe.

Every frame is 20 serial clocks: a 4-bit command followed by a 16-bit payload, both least significant bit first. The host puts each outgoing bit on the data line while the serial clock is low and samples incoming bits when the clock falls. The serial clock half period and the turnaround delay are parameters counted in system clocks. The host drives the data line only while it is sending, so the target may drive the line in the read window and while the host is idle.

Top module: `serprog_read_seq`

## Requirements
- R1: After reset the serial clock is low, the data-line enable is low, and busy and done are low.
- R2: Each frame has exactly 20 serial clock pulses, a 4-bit command and then a 16-bit payload, both sent least significant bit first. The host changes its data output only while the serial clock is low, so every rising edge finds data that was set in an earlier system cycle.
- R3: The first six frames carry command 0000. Their payloads, in the order sent, are 0x0E00 plus address bits 21..16 zero-extended to a byte, 0x6EF8, 0x0E00 plus address bits 15..8, 0x6EF7, 0x0E00 plus address bits 7..0, and 0x6EF6.
- R4: The seventh frame carries command 1001, so the bits on the line are 1,0,0,1. The host then drives 0 for the first 8 payload clocks.
- R5: The host releases the data line at the falling edge of the 8th payload clock of the read frame. The serial clock then stays low for TURN_CYC plus HALF_DIV system cycles before its next rising edge.
- R6: The host samples the data line at the falling edge of each of the last 8 read clocks, with no data-line enable. The first sampled bit becomes bit 0 of the result. The result is valid on read_data_o in the cycle where done_o is high.
- R7: Every high phase of the serial clock lasts exactly HALF_DIV system cycles.
- R8: busy_o rises in the cycle after an accepted start and stays high until done_o. done_o is a one-cycle pulse, and busy_o is low in that cycle.
- R9: A start pulse while busy_o is high is ignored. The address in use and the serial sequence do not change, and no extra done pulse follows.
- R10: The data-line enable is low after the 16th read clock and whenever the host is idle.
- R11: Any address from 000000h to 3FFFFFh is sent unaltered, including the two all-zero and all-one extremes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle request to read a byte |
| addr_i | input | 22 | Target address, captured with an accepted start |
| pclk_o | output | 1 | Serial clock to the target |
| pdat_o | output | 1 | Host data toward the target |
| pdat_oe_o | output | 1 | High while the host drives the data line |
| pdat_i | input | 1 | Data line as seen by the host |
| busy_o | output | 1 | A read sequence is in progress |
| done_o | output | 1 | One-cycle strobe: read_data_o is valid |
| read_data_o | output | 8 | Byte returned by the target |

## Verification
The hardest point to reach is the handover in the middle of the read frame. To test it, a target model has to start driving the line only after the host has let go, and the length of the low-clock gap has to be measured. The bench models the target. It counts serial clock rises that occur with the enable low and shifts out a known byte on each of those rises. It also counts system cycles from the enable's fall to the next rising clock, and collects every host-driven bit against an expected frame stream built from the address. A start pulse injected in the middle of a read with a different address covers the ignore rule. Random addresses mixed with the two address extremes cover the byte split of the pointer.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  localparam int ADDR_W  = 22;
  localparam int CMD_W   = 4;
  localparam int PAY_W   = 16;
  localparam int FRAME_W = CMD_W + PAY_W;
  localparam int N_TXN   = 7;
  localparam int BYTE_W  = 8;

  localparam logic [CMD_W-1:0] CMD_CORE  = 4'b0000;
  localparam logic [CMD_W-1:0] CMD_TREAD = 4'b1001;
  localparam logic [7:0] OP_LOADLIT  = 8'h0E;
  localparam logic [7:0] OP_STOREREG = 8'h6E;
  localparam logic [7:0] REG_PTR_UP  = 8'hF8;
  localparam logic [7:0] REG_PTR_MID = 8'hF7;
  localparam logic [7:0] REG_PTR_LO  = 8'hF6;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2,
    PH_TURN = 2'd3
  } phase_e;
endpackage

// File: rtl/serprog_pace_cnt.sv
module serprog_pace_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign last_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || last_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: the phase counter never passes its limit, so each phase is exactly LIMIT cycles
  assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/serprog_frame.sv
module serprog_frame
  import serprog_pkg::*;
(
  input  logic [2:0]        txn_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [4:0]        sel_i,
  output logic              bit_o
);
  logic [FRAME_W-1:0] word;

  always_comb begin
    case (txn_i)
      3'd0:    word = {OP_LOADLIT,  2'b00, addr_i[21:16], CMD_CORE};
      3'd1:    word = {OP_STOREREG, REG_PTR_UP,           CMD_CORE};
      3'd2:    word = {OP_LOADLIT,  addr_i[15:8],         CMD_CORE};
      3'd3:    word = {OP_STOREREG, REG_PTR_MID,          CMD_CORE};
      3'd4:    word = {OP_LOADLIT,  addr_i[7:0],          CMD_CORE};
      3'd5:    word = {OP_STOREREG, REG_PTR_LO,           CMD_CORE};
      default: word = {{PAY_W{1'b0}},                     CMD_TREAD};
    endcase
  end

  assign bit_o = word[sel_i];
endmodule

// File: rtl/serprog_rx_shift.sv
module serprog_rx_shift #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en_i,
  input  logic             sdi_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] rx_q, rx_d;

  always_comb begin
    rx_d = rx_q;
    if (shift_en_i) rx_d = {sdi_i, rx_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= '0;
    else        rx_q <= rx_d;
  end

  assign data_o = rx_q;
endmodule

// File: rtl/serprog_read_seq.sv
module serprog_read_seq
  import serprog_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int TURN_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              pclk_o,
  output logic              pdat_o,
  output logic              pdat_oe_o,
  input  logic              pdat_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] read_data_o
);
  localparam logic [2:0] READ_TXN = 3'(N_TXN - 1);
  localparam logic [4:0] LAST_BIT = 5'(FRAME_W - 1);
  localparam logic [4:0] TURN_BIT = 5'(CMD_W + BYTE_W - 1);
  localparam logic [4:0] RX_FIRST = 5'(CMD_W + BYTE_W);

  phase_e            ph_q, ph_d;
  logic [2:0]        txn_q, txn_d;
  logic [4:0]        bit_q, bit_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;
  logic              half_last, turn_last;
  logic              sample_en, frame_bit;
  logic              in_read, rx_window;

  serprog_pace_cnt #(.LIMIT(HALF_DIV)) half_cnt_i (
    .clk(clk), .rst_n(rst_n),
    .run_i(ph_q == PH_LOW || ph_q == PH_HIGH),
    .last_o(half_last)
  );

  serprog_pace_cnt #(.LIMIT(TURN_CYC)) turn_cnt_i (
    .clk(clk), .rst_n(rst_n),
    .run_i(ph_q == PH_TURN),
    .last_o(turn_last)
  );

  serprog_frame frame_i (
    .txn_i(txn_q), .addr_i(addr_q), .sel_i(bit_q), .bit_o(frame_bit)
  );

  serprog_rx_shift #(.WIDTH(BYTE_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .shift_en_i(sample_en),
    .sdi_i(pdat_i), .data_o(read_data_o)
  );

  assign in_read   = (txn_q == READ_TXN);
  assign rx_window = in_read && (bit_q >= RX_FIRST);

  always_comb begin
    ph_d      = ph_q;
    txn_d     = txn_q;
    bit_d     = bit_q;
    addr_d    = addr_q;
    done_d    = 1'b0;
    sample_en = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          addr_d = addr_i;
          txn_d  = '0;
          bit_d  = '0;
          ph_d   = PH_LOW;
        end
      end
      PH_LOW: begin
        if (half_last) ph_d = PH_HIGH;
      end
      PH_HIGH: begin
        if (half_last) begin
          sample_en = rx_window;
          if (bit_q == LAST_BIT) begin
            bit_d = '0;
            if (in_read) begin
              ph_d   = PH_IDLE;
              done_d = 1'b1;
            end else begin
              txn_d = txn_q + 1'b1;
              ph_d  = PH_LOW;
            end
          end else begin
            bit_d = bit_q + 1'b1;
            ph_d  = (in_read && bit_q == TURN_BIT) ? PH_TURN : PH_LOW;
          end
        end
      end
      default: begin
        if (turn_last) ph_d = PH_LOW;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      txn_q  <= '0;
      bit_q  <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      txn_q  <= txn_d;
      bit_q  <= bit_d;
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign busy_o    = (ph_q != PH_IDLE);
  assign done_o    = done_q;
  assign pclk_o    = (ph_q == PH_HIGH);
  assign pdat_oe_o = busy_o && (ph_q != PH_TURN) && !rx_window;
  assign pdat_o    = pdat_oe_o && frame_bit;

  // R10: host leaves the line and clock quiet whenever idle
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!pdat_oe_o && !pclk_o));

  // R8: done lands exactly as the sequence ends
  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R8: done is a single-cycle strobe
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: the captured address cannot move while a read is running
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(addr_q));

  // R2: data and enable were already settled when the clock rises
  assert_setup_before_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pclk_o) |-> ($stable(pdat_o) && $stable(pdat_oe_o)));

  // R2: data is held for the whole high phase
  assert_hold_while_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pclk_o && $past(pclk_o)) |-> $stable(pdat_o));

  // R5: the line is released only at a falling clock with the clock low
  assert_release_clock_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pdat_oe_o) && busy_o) |-> (!pclk_o && $past(pclk_o)));
endmodule

// File: tb/serprog_read_seq_tb.sv
module serprog_read_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;
  localparam int TURN_CYC   = 5;
  localparam int HOST_BITS  = 6 * 20 + 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [21:0] addr_i = '0;
  logic        pclk_o, pdat_o, pdat_oe_o, busy_o, done_o;
  logic        pdat_i = 1'b0;
  logic [7:0]  read_data_o;

  int n_checks = 0;
  int n_fail   = 0;

  // monitor state
  logic          prev_pclk = 1'b0, prev_oe = 1'b0;
  logic [HOST_BITS-1:0] hbits;
  int            hcnt = 0, rrise = 0, tk = 0;
  int            low_cnt = 0, gap = -1, hi_run = 0, hi_bad = 0;
  logic          counting = 1'b0;
  logic [7:0]    tgt_byte = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serprog_read_seq #(.HALF_DIV(HALF_DIV), .TURN_CYC(TURN_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .pclk_o(pclk_o), .pdat_o(pdat_o), .pdat_oe_o(pdat_oe_o), .pdat_i(pdat_i),
    .busy_o(busy_o), .done_o(done_o), .read_data_o(read_data_o)
  );

  function automatic logic [19:0] exp_frame(int t, logic [21:0] a);
    case (t)
      0:       return {8'h0E, 2'b00, a[21:16], 4'b0000};
      1:       return {16'h6EF8, 4'b0000};
      2:       return {8'h0E, a[15:8], 4'b0000};
      3:       return {16'h6EF7, 4'b0000};
      4:       return {8'h0E, a[7:0], 4'b0000};
      5:       return {16'h6EF6, 4'b0000};
      default: return {16'h0000, 4'b1001};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // target model and line monitor, evaluated away from the active edge
  always @(negedge clk) begin
    if (pclk_o && !prev_pclk) begin
      if (pdat_oe_o) begin
        if (hcnt < HOST_BITS) hbits[hcnt] = pdat_o;
        hcnt++;
      end else begin
        pdat_i = tgt_byte[tk % 8];
        tk++;
        rrise++;
      end
      if (counting) begin
        gap = low_cnt;
        counting = 1'b0;
      end
    end else if (counting && !pclk_o) begin
      low_cnt++;
    end
    if (prev_oe && !pdat_oe_o && busy_o) begin
      counting = 1'b1;
      low_cnt = 1;
    end
    if (pclk_o) hi_run++;
    else if (prev_pclk) begin
      if (hi_run != HALF_DIV) hi_bad++;
      hi_run = 0;
    end
    prev_pclk = pclk_o;
    prev_oe   = pdat_oe_o;
  end

  task automatic run_read(input logic [21:0] a, input logic [7:0] b,
                          input bit inject, input string rq);
    int cyc;
    int bad_setup, bad_read;
    @(negedge clk);
    hcnt = 0; rrise = 0; tk = 0; gap = -1; hi_bad = 0; counting = 1'b0;
    tgt_byte = b;
    addr_i  = a;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R8", "busy after start", busy_o, 1);
    cyc = 0;
    while (done_o !== 1'b1 && cyc < 20000) begin
      if (inject && cyc == 40) begin
        addr_i  = ~a;
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    check(cyc < 20000, "R8", "done reached", cyc, 0);
    check(busy_o === 1'b0, "R8", "busy low with done", busy_o, 0);
    check(read_data_o === b, "R6", "returned byte", read_data_o, b);
    check(rrise == 8, "R6", "read clocks with line released", rrise, 8);
    check(hcnt == HOST_BITS, "R2", "host-driven clocks", hcnt, HOST_BITS);
    bad_setup = 0;
    bad_read  = 0;
    for (int i = 0; i < HOST_BITS; i++) begin
      logic [19:0] fr;
      fr = exp_frame(i / 20, a);
      if (hbits[i] !== fr[i % 20]) begin
        if (i < 120) bad_setup++;
        else         bad_read++;
      end
    end
    check(bad_setup == 0, rq, "pointer setup bit stream mismatches", bad_setup, 0);
    check(bad_read == 0, "R4", "read command and zero bits mismatches", bad_read, 0);
    check(gap == TURN_CYC + HALF_DIV, "R5", "low cycles from release to next rise",
          gap, TURN_CYC + HALF_DIV);
    check(hi_bad == 0, "R7", "high phases of wrong length", hi_bad, 0);
    check(pdat_oe_o === 1'b0, "R10", "line released at end", pdat_oe_o, 0);
    @(negedge clk);
    check(done_o === 1'b0, "R8", "done one cycle only", done_o, 0);
    if (inject) begin
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        check(done_o === 1'b0 && busy_o === 1'b0, "R9", "no extra read after ignored start",
              {done_o, busy_o}, 0);
      end
    end
  endtask

  initial begin
    #(longint'(200000) * CLK_PERIOD);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet outputs after reset
    check(pclk_o === 1'b0 && pdat_oe_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
          "R1", "reset outputs", {pclk_o, pdat_oe_o, busy_o, done_o}, 0);
    // R10: idle with line released
    repeat (5) @(negedge clk);
    check(pdat_oe_o === 1'b0, "R10", "idle enable", pdat_oe_o, 0);

    run_read(22'h000000, 8'hA5, 1'b0, "R11");
    run_read(22'h3FFFFF, 8'h01, 1'b0, "R11");
    run_read(22'h2A5C3E, 8'h80, 1'b1, "R9");
    for (int n = 0; n < 6; n++) begin
      logic [21:0] ra;
      logic [7:0]  rb;
      ra = 22'($urandom());
      rb = 8'($urandom());
      run_read(ra, rb, 1'b0, "R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule